// File: doc/BRIEF.md
# DMA Register Bank

This block is the software-visible register store of a multi-channel DMA engine. A processor reaches it through a plain 32-bit write/read bus: each write takes effect on the next clock edge, and read data is decoded combinationally from the address. The transfer datapath lives elsewhere. It reads the live register values from dedicated output ports. It writes back progress (memory address, remaining count, tag address) and raises status events through hardware update inputs.

The address is split into a page field and an in-page offset. Page `c` holds the register set of channel `c`, and one further page holds the global registers. Every mapped register sits on a 16-byte boundary. Each register keeps only its implemented bits: the others read zero whatever is written. The status register does not simply store what is written. Ones written to its event-count positions flip those bits, and ones written to its flag positions clear them.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register, and every output port that mirrors one, reads zero.
- R2: Address bits 15:12 select the page: page c (c < NUM_CH) is channel c, page 0xE is global. Address bits 6:4 select the register, with bits 3:0 zero and bits 11:7 zero. Channel order is control, memory address, count, tag address, save 0, save 1, packet flag. Global order is control, status, priority, stall count, ring base, ring offset, stall address. Writes to one register or channel leave all others untouched, and the output ports mirror the stored values.
- R3: A bus write to status toggles bits 30:29 and 25:16 where the data holds ones, and clears bits 15:13 and 9:0 where the data holds ones. Zero data bits leave the corresponding status bits alone. Status bits 31, 28:26 and 12:10 always read zero.
- R4: Priority keeps bits 31, 25:16 and 9:0. Global control keeps bits 9:0. Stall count keeps bits 23:16 and 7:0. All other bits of these registers read zero.
- R5: Memory address, tag address, both save registers, ring base, ring offset and stall address keep bits 30:4. Their bit 31 and bits 3:0 read zero.
- R6: Channel control keeps bits 8:0, count keeps bits 15:0, and packet flag keeps all 32 bits.
- R7: An address that is not mapped reads zero, and a write to it changes no register. Unmapped addresses are: register field 7, nonzero bits 3:0, nonzero bits 11:7, or an unassigned page.
- R8: Ones on the hardware status input set the matching status bits on the next edge, limited to the implemented positions.
- R9: When a channel's hardware update strobe is high, that channel loads its memory address, count and tag address from its input slices on the next edge, under the same masks as bus writes.
- R10: When a bus write and a hardware update target the same register in one cycle, the bus value is stored and the hardware value is lost. A bus write to status discards that cycle's hardware set. Hardware updates to registers the bus does not write in that cycle still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_stat_set | input | 32 | Hardware status bits to set |
| hw_ch_upd | input | NUM_CH | Per-channel hardware update strobe |
| hw_ch_mem | input | NUM_CH*32 | Per-channel new memory address |
| hw_ch_cnt | input | NUM_CH*16 | Per-channel new count |
| hw_ch_tag | input | NUM_CH*32 | Per-channel new tag address |
| ch_ctrl_o | output | NUM_CH*9 | Per-channel control value |
| ch_mem_o | output | NUM_CH*32 | Per-channel memory address |
| ch_cnt_o | output | NUM_CH*16 | Per-channel count |
| ch_tag_o | output | NUM_CH*32 | Per-channel tag address |
| glob_ctrl_o | output | 10 | Global control value |
| glob_stat_o | output | 32 | Status value |
| glob_prio_o | output | 32 | Priority/enable value |

## Verification
Two pairs of functions can land in the same cycle. A bus write can meet a hardware update of the same channel, and a bus write to status can meet a hardware status set. The bench raises both sources on the same falling edge so that one rising edge captures them together. It then reads the registers back. The bus value must be present and the hardware value absent, while hardware-driven fields the bus did not touch, or a status set that coincides with a write to a different register, must still show.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
    localparam int DATA_W  = 32;
    localparam int CCTRL_W = 9;
    localparam int CNT_W   = 16;
    localparam int GCTRL_W = 10;
    localparam int IDX_W   = 3;

    localparam logic [DATA_W-1:0] MSK_GCTRL    = 32'h0000_03FF;
    localparam logic [DATA_W-1:0] MSK_STAT_TGL = 32'h63FF_0000;
    localparam logic [DATA_W-1:0] MSK_STAT_CLR = 32'h0000_E3FF;
    localparam logic [DATA_W-1:0] MSK_STAT_ALL = MSK_STAT_TGL | MSK_STAT_CLR;
    localparam logic [DATA_W-1:0] MSK_PRIO     = 32'h83FF_03FF;
    localparam logic [DATA_W-1:0] MSK_STALL    = 32'h00FF_00FF;
    localparam logic [DATA_W-1:0] MSK_ADDR     = 32'h7FFF_FFF0;
    localparam logic [DATA_W-1:0] MSK_CCTRL    = 32'h0000_01FF;
    localparam logic [DATA_W-1:0] MSK_COUNT    = 32'h0000_FFFF;
    localparam logic [DATA_W-1:0] MSK_FLAG     = 32'hFFFF_FFFF;

    // channel register slots (offset = slot * 16)
    localparam logic [IDX_W-1:0] CH_CTRL = 3'd0;
    localparam logic [IDX_W-1:0] CH_MEM  = 3'd1;
    localparam logic [IDX_W-1:0] CH_CNT  = 3'd2;
    localparam logic [IDX_W-1:0] CH_TAG  = 3'd3;
    localparam logic [IDX_W-1:0] CH_SAV0 = 3'd4;
    localparam logic [IDX_W-1:0] CH_SAV1 = 3'd5;
    localparam logic [IDX_W-1:0] CH_FLAG = 3'd6;

    // global register slots
    localparam logic [IDX_W-1:0] GL_CTRL  = 3'd0;
    localparam logic [IDX_W-1:0] GL_STAT  = 3'd1;
    localparam logic [IDX_W-1:0] GL_PRIO  = 3'd2;
    localparam logic [IDX_W-1:0] GL_STALL = 3'd3;
    localparam logic [IDX_W-1:0] GL_RBASE = 3'd4;
    localparam logic [IDX_W-1:0] GL_ROFS  = 3'd5;
    localparam logic [IDX_W-1:0] GL_SADR  = 3'd6;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] mem;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] tag;
        logic [DATA_W-1:0] sav0;
        logic [DATA_W-1:0] sav1;
        logic [DATA_W-1:0] flag;
    } chan_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] stat;
        logic [DATA_W-1:0] prio;
        logic [DATA_W-1:0] stall;
        logic [DATA_W-1:0] rbase;
        logic [DATA_W-1:0] rofs;
        logic [DATA_W-1:0] sadr;
    } glob_regs_t;
endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec #(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int NUM_CH      = 3,
    parameter int GLOBAL_PAGE = 14
) (
    input  logic [ADDR_W-1:0]             addr,
    output logic [NUM_CH-1:0]             ch_hit,
    output logic                          glob_hit,
    output logic [dmareg_pkg::IDX_W-1:0]  idx
);
    localparam int OFS_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] page;
    logic [OFS_W-1:0]  ofs;
    logic              ofs_ok;

    assign page   = addr[ADDR_W-1:OFS_W];
    assign ofs    = addr[OFS_W-1:0];
    assign idx    = ofs[6:4];
    // slot 7, sub-slot bytes and anything above 0x7F are holes
    assign ofs_ok = (ofs[OFS_W-1:7] == '0) && (ofs[3:0] == 4'h0) && (ofs[6:4] != 3'd7);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign ch_hit[c] = ofs_ok && (page == PAGE_W'(c));
    end

    assign glob_hit = ofs_ok && (page == PAGE_W'(GLOBAL_PAGE));
endmodule

// File: rtl/dma_glob_regs.sv
module dma_glob_regs
    import dmareg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  hw_set,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [GCTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0]  stat_o,
    output logic [DATA_W-1:0]  prio_o
);
    glob_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        regs_d.stat = regs_q.stat | (hw_set & MSK_STAT_ALL);
        if (wr_en) begin
            case (wr_idx)
                GL_CTRL:  regs_d.ctrl  = wr_data & MSK_GCTRL;
                // bus write wins: built from the old value, hardware set dropped
                GL_STAT:  regs_d.stat  = (regs_q.stat ^ (wr_data & MSK_STAT_TGL))
                                         & ~(wr_data & MSK_STAT_CLR);
                GL_PRIO:  regs_d.prio  = wr_data & MSK_PRIO;
                GL_STALL: regs_d.stall = wr_data & MSK_STALL;
                GL_RBASE: regs_d.rbase = wr_data & MSK_ADDR;
                GL_ROFS:  regs_d.rofs  = wr_data & MSK_ADDR;
                GL_SADR:  regs_d.sadr  = wr_data & MSK_ADDR;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (rd_idx)
            GL_CTRL:  rd_data = regs_q.ctrl;
            GL_STAT:  rd_data = regs_q.stat;
            GL_PRIO:  rd_data = regs_q.prio;
            GL_STALL: rd_data = regs_q.stall;
            GL_RBASE: rd_data = regs_q.rbase;
            GL_ROFS:  rd_data = regs_q.rofs;
            GL_SADR:  rd_data = regs_q.sadr;
            default:  rd_data = '0;
        endcase
    end

    assign ctrl_o = regs_q.ctrl[GCTRL_W-1:0];
    assign stat_o = regs_q.stat;
    assign prio_o = regs_q.prio;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dmareg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               hw_en,
    input  logic [DATA_W-1:0]  hw_mem,
    input  logic [CNT_W-1:0]   hw_cnt,
    input  logic [DATA_W-1:0]  hw_tag,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [DATA_W-1:0]  rd_data,
    output logic [CCTRL_W-1:0] ctrl_o,
    output logic [DATA_W-1:0]  mem_o,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [DATA_W-1:0]  tag_o
);
    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (hw_en) begin
            regs_d.mem = hw_mem & MSK_ADDR;
            regs_d.cnt = {{(DATA_W-CNT_W){1'b0}}, hw_cnt};
            regs_d.tag = hw_tag & MSK_ADDR;
        end
        // bus write applied last so it overrides a same-cycle hardware value
        if (wr_en) begin
            case (wr_idx)
                CH_CTRL: regs_d.ctrl = wr_data & MSK_CCTRL;
                CH_MEM:  regs_d.mem  = wr_data & MSK_ADDR;
                CH_CNT:  regs_d.cnt  = wr_data & MSK_COUNT;
                CH_TAG:  regs_d.tag  = wr_data & MSK_ADDR;
                CH_SAV0: regs_d.sav0 = wr_data & MSK_ADDR;
                CH_SAV1: regs_d.sav1 = wr_data & MSK_ADDR;
                CH_FLAG: regs_d.flag = wr_data & MSK_FLAG;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (rd_idx)
            CH_CTRL: rd_data = regs_q.ctrl;
            CH_MEM:  rd_data = regs_q.mem;
            CH_CNT:  rd_data = regs_q.cnt;
            CH_TAG:  rd_data = regs_q.tag;
            CH_SAV0: rd_data = regs_q.sav0;
            CH_SAV1: rd_data = regs_q.sav1;
            CH_FLAG: rd_data = regs_q.flag;
            default: rd_data = '0;
        endcase
    end

    assign ctrl_o = regs_q.ctrl[CCTRL_W-1:0];
    assign mem_o  = regs_q.mem;
    assign cnt_o  = regs_q.cnt[CNT_W-1:0];
    assign tag_o  = regs_q.tag;
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dmareg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int NUM_CH      = 3,
    parameter int GLOBAL_PAGE = 14
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [DATA_W-1:0]         hw_stat_set,
    input  logic [NUM_CH-1:0]         hw_ch_upd,
    input  logic [NUM_CH*DATA_W-1:0]  hw_ch_mem,
    input  logic [NUM_CH*CNT_W-1:0]   hw_ch_cnt,
    input  logic [NUM_CH*DATA_W-1:0]  hw_ch_tag,
    output logic [NUM_CH*CCTRL_W-1:0] ch_ctrl_o,
    output logic [NUM_CH*DATA_W-1:0]  ch_mem_o,
    output logic [NUM_CH*CNT_W-1:0]   ch_cnt_o,
    output logic [NUM_CH*DATA_W-1:0]  ch_tag_o,
    output logic [GCTRL_W-1:0]        glob_ctrl_o,
    output logic [DATA_W-1:0]         glob_stat_o,
    output logic [DATA_W-1:0]         glob_prio_o
);
    logic [NUM_CH-1:0] ch_hit;
    logic              glob_hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] glob_rd;
    logic [DATA_W-1:0] ch_rd [NUM_CH];

    dma_addr_dec #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_CH(NUM_CH), .GLOBAL_PAGE(GLOBAL_PAGE)
    ) i_dec (
        .addr(bus_addr), .ch_hit(ch_hit), .glob_hit(glob_hit), .idx(idx)
    );

    dma_glob_regs i_glob (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_we && glob_hit), .wr_idx(idx), .wr_data(bus_wdata),
        .hw_set(hw_stat_set),
        .rd_idx(idx), .rd_data(glob_rd),
        .ctrl_o(glob_ctrl_o), .stat_o(glob_stat_o), .prio_o(glob_prio_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_regs i_chan (
            .clk(clk), .rst_n(rst_n),
            .wr_en(bus_we && ch_hit[c]), .wr_idx(idx), .wr_data(bus_wdata),
            .hw_en(hw_ch_upd[c]),
            .hw_mem(hw_ch_mem[c*DATA_W +: DATA_W]),
            .hw_cnt(hw_ch_cnt[c*CNT_W +: CNT_W]),
            .hw_tag(hw_ch_tag[c*DATA_W +: DATA_W]),
            .rd_idx(idx), .rd_data(ch_rd[c]),
            .ctrl_o(ch_ctrl_o[c*CCTRL_W +: CCTRL_W]),
            .mem_o(ch_mem_o[c*DATA_W +: DATA_W]),
            .cnt_o(ch_cnt_o[c*CNT_W +: CNT_W]),
            .tag_o(ch_tag_o[c*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        bus_rdata = glob_hit ? glob_rd : '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) bus_rdata = ch_rd[c];
        end
    end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk
    import dmareg_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PAGE_W      = 4,
    parameter int NUM_CH      = 3,
    parameter int GLOBAL_PAGE = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_we,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        hw_stat_set,
    input logic [NUM_CH-1:0]        hw_ch_upd,
    input logic [NUM_CH*DATA_W-1:0] ch_mem_o,
    input logic [NUM_CH*CNT_W-1:0]  ch_cnt_o,
    input logic [GCTRL_W-1:0]       glob_ctrl_o,
    input logic [DATA_W-1:0]        glob_stat_o,
    input logic [DATA_W-1:0]        glob_prio_o
);
    localparam int OFS_W = ADDR_W - PAGE_W;
    localparam logic [ADDR_W-1:0] GBASE     = ADDR_W'(GLOBAL_PAGE) << OFS_W;
    localparam logic [ADDR_W-1:0] STAT_ADDR = GBASE | ADDR_W'(16'h0010);
    localparam logic [ADDR_W-1:0] HOLE_ADDR = GBASE | ADDR_W'(16'h0070);

    logic stat_wr;
    assign stat_wr = bus_we && (bus_addr == STAT_ADDR);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (glob_stat_o == '0 && glob_prio_o == '0 && glob_ctrl_o == '0
                          && ch_mem_o == '0 && ch_cnt_o == '0));

    assert_stat_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> glob_stat_o == (($past(glob_stat_o) ^ ($past(bus_wdata) & MSK_STAT_TGL))
                                    & ~($past(bus_wdata) & MSK_STAT_CLR)));

    assert_prio_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_prio_o & ~MSK_PRIO) == '0);

    assert_stat_hwset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_wr && hw_stat_set != '0) |=>
        ((glob_stat_o & $past(hw_stat_set & MSK_STAT_ALL)) == $past(hw_stat_set & MSK_STAT_ALL)));

    assert_hole_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == HOLE_ADDR && hw_stat_set == '0 && hw_ch_upd == '0) |=>
        ($stable(glob_stat_o) && $stable(glob_prio_o) && $stable(glob_ctrl_o)
         && $stable(ch_mem_o) && $stable(ch_cnt_o)));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
        localparam logic [ADDR_W-1:0] CNT_ADDR = (ADDR_W'(c) << OFS_W) | ADDR_W'(16'h0020);

        assert_mem_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_mem_o[c*DATA_W +: DATA_W] & ~MSK_ADDR) == '0);

        assert_bus_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == CNT_ADDR && hw_ch_upd[c]) |=>
            ch_cnt_o[c*CNT_W +: CNT_W] == $past(bus_wdata[CNT_W-1:0]));
    end
endmodule

bind dma_regbank dma_regbank_chk #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_CH(NUM_CH), .GLOBAL_PAGE(GLOBAL_PAGE)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hw_stat_set(hw_stat_set), .hw_ch_upd(hw_ch_upd),
    .ch_mem_o(ch_mem_o), .ch_cnt_o(ch_cnt_o), .glob_ctrl_o(glob_ctrl_o),
    .glob_stat_o(glob_stat_o), .glob_prio_o(glob_prio_o)
);

// File: tb/test_dma_regbank.sv
`timescale 1ns/1ps
module test_dma_regbank;
    localparam int NCH = 3;
    localparam logic [15:0] GB = 16'hE000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   hw_stat_set = '0;
    logic [NCH-1:0]    hw_ch_upd = '0;
    logic [NCH*32-1:0] hw_ch_mem = '0;
    logic [NCH*16-1:0] hw_ch_cnt = '0;
    logic [NCH*32-1:0] hw_ch_tag = '0;
    logic [NCH*9-1:0]  ch_ctrl_o;
    logic [NCH*32-1:0] ch_mem_o;
    logic [NCH*16-1:0] ch_cnt_o;
    logic [NCH*32-1:0] ch_tag_o;
    logic [9:0]        glob_ctrl_o;
    logic [31:0]       glob_stat_o;
    logic [31:0]       glob_prio_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_regbank #(.ADDR_W(16), .PAGE_W(4), .NUM_CH(NCH), .GLOBAL_PAGE(14)) i_dma_regbank (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_stat_set(hw_stat_set),
        .hw_ch_upd(hw_ch_upd), .hw_ch_mem(hw_ch_mem), .hw_ch_cnt(hw_ch_cnt),
        .hw_ch_tag(hw_ch_tag), .ch_ctrl_o(ch_ctrl_o), .ch_mem_o(ch_mem_o),
        .ch_cnt_o(ch_cnt_o), .ch_tag_o(ch_tag_o), .glob_ctrl_o(glob_ctrl_o),
        .glob_stat_o(glob_stat_o), .glob_prio_o(glob_prio_o)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ch_addr(input int c, input int idx);
        return 16'((c << 12) | (idx << 4));
    endfunction

    function automatic logic [31:0] ch_mask(input int idx);
        case (idx)
            0: return 32'h0000_01FF;
            2: return 32'h0000_FFFF;
            6: return 32'hFFFF_FFFF;
            default: return 32'h7FFF_FFF0;
        endcase
    endfunction

    function automatic logic [31:0] gl_mask(input int idx);
        case (idx)
            0: return 32'h0000_03FF;
            2: return 32'h83FF_03FF;
            3: return 32'h00FF_00FF;
            default: return 32'h7FFF_FFF0;
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic hw_set(input logic [31:0] v);
        @(negedge clk);
        hw_stat_set = v;
        @(negedge clk);
        hw_stat_set = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < NCH; c++)
            for (int i = 0; i < 7; i++) begin
                rd(ch_addr(c, i), d);
                check("R1", $sformatf("ch%0d slot%0d after reset", c, i), d, 32'h0);
            end
        for (int i = 0; i < 7; i++) begin
            rd(GB | 16'(i << 4), d);
            check("R1", $sformatf("global slot%0d after reset", i), d, 32'h0);
        end
        check("R1", "glob_stat_o after reset", glob_stat_o, 32'h0);
        check("R1", "ch_mem_o after reset", ch_mem_o[31:0], 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] d, pat, v;
        for (int p = 0; p < 3; p++) begin
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h5555_AAAA : 32'hAAAA_5555;
            for (int c = 0; c < NCH; c++)
                for (int i = 0; i < 7; i++)
                    wr(ch_addr(c, i), pat ^ 32'((c << 20) | (i << 8)));
            for (int i = 0; i < 7; i++)
                if (i != 1) wr(GB | 16'(i << 4), pat ^ 32'(i << 8));
            for (int c = 0; c < NCH; c++)
                for (int i = 0; i < 7; i++) begin
                    v = pat ^ 32'((c << 20) | (i << 8));
                    rd(ch_addr(c, i), d);
                    if (i == 0 || i == 2 || i == 6)
                        check("R6", $sformatf("ch%0d slot%0d pat%0d", c, i, p), d, v & ch_mask(i));
                    else
                        check("R5", $sformatf("ch%0d slot%0d pat%0d", c, i, p), d, v & ch_mask(i));
                    if (i == 0) check("R2", "ch_ctrl_o mirror", 32'(ch_ctrl_o[c*9 +: 9]), v & ch_mask(0));
                    if (i == 1) check("R2", "ch_mem_o mirror", ch_mem_o[c*32 +: 32], v & ch_mask(1));
                    if (i == 2) check("R2", "ch_cnt_o mirror", 32'(ch_cnt_o[c*16 +: 16]), v & ch_mask(2));
                    if (i == 3) check("R2", "ch_tag_o mirror", ch_tag_o[c*32 +: 32], v & ch_mask(3));
                end
            for (int i = 0; i < 7; i++)
                if (i != 1) begin
                    v = pat ^ 32'(i << 8);
                    rd(GB | 16'(i << 4), d);
                    if (i <= 3)
                        check("R4", $sformatf("global slot%0d pat%0d", i, p), d, v & gl_mask(i));
                    else
                        check("R5", $sformatf("global slot%0d pat%0d", i, p), d, v & gl_mask(i));
                end
            check("R2", "glob_ctrl_o mirror", 32'(glob_ctrl_o), pat & gl_mask(0));
            check("R2", "glob_prio_o mirror", glob_prio_o, (pat ^ 32'h200) & gl_mask(2));
            check("R3", "status untouched by other writes", glob_stat_o, 32'h0);
        end
    endtask

    task automatic t_status();
        logic [31:0] d;
        logic [15:0] sa;
        sa = GB | 16'h0010;
        wr(sa, 32'hFFFF_FFFF); rd(sa, d); check("R3", "toggle from zero", d, 32'h63FF_0000);
        wr(sa, 32'h63FF_0000); rd(sa, d); check("R3", "toggle back", d, 32'h0);
        hw_set(32'hFFFF_FFFF); rd(sa, d); check("R8", "hw set all", d, 32'h63FF_E3FF);
        check("R8", "glob_stat_o after set", glob_stat_o, 32'h63FF_E3FF);
        wr(sa, 32'h0000_E3FF); rd(sa, d); check("R3", "clear low flags", d, 32'h63FF_0000);
        wr(sa, 32'h0001_0000); rd(sa, d); check("R3", "toggle one bit", d, 32'h63FE_0000);
        wr(sa, 32'h0); rd(sa, d); check("R3", "zero write no change", d, 32'h63FE_0000);
        // same-cycle bus status write and hardware set
        @(negedge clk);
        bus_addr = sa; bus_wdata = 32'h0; bus_we = 1'b1; hw_stat_set = 32'h1;
        @(negedge clk);
        bus_we = 1'b0; hw_stat_set = '0;
        rd(sa, d); check("R10", "bus status write drops hw set", d, 32'h63FE_0000);
        hw_set(32'h1); rd(sa, d); check("R8", "hw set bit0", d, 32'h63FE_0001);
        // hardware set alongside a write to a different register
        @(negedge clk);
        bus_addr = GB; bus_wdata = 32'h5; bus_we = 1'b1; hw_stat_set = 32'h2;
        @(negedge clk);
        bus_we = 1'b0; hw_stat_set = '0;
        rd(sa, d); check("R10", "hw set survives other write", d, 32'h63FE_0003);
        rd(GB, d); check("R10", "ctrl written same cycle", d, 32'h5);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(ch_addr(0, 0), 32'h0AB);
        wr(ch_addr(1, 0), 32'h0CD);
        wr(GB | 16'h0020, 32'h8001_0001);
        wr(GB | 16'h0070, 32'hFFFF_FFFF);
        wr(16'h0008, 32'hFFFF_FFFF);
        wr(16'h1100, 32'hFFFF_FFFF);
        wr(16'h5000, 32'hFFFF_FFFF);
        wr(16'h0070, 32'hFFFF_FFFF);
        rd(GB | 16'h0070, d); check("R7", "read global slot7", d, 32'h0);
        rd(16'h0008, d); check("R7", "read sub-slot byte", d, 32'h0);
        rd(16'h1100, d); check("R7", "read high offset", d, 32'h0);
        rd(16'h5000, d); check("R7", "read unassigned page", d, 32'h0);
        rd(ch_addr(0, 0), d); check("R7", "ch0 ctrl unchanged", d, 32'h0AB);
        rd(ch_addr(1, 0), d); check("R7", "ch1 ctrl unchanged", d, 32'h0CD);
        rd(GB | 16'h0020, d); check("R7", "prio unchanged", d, 32'h8001_0001);
        check("R7", "status unchanged", glob_stat_o, 32'h63FE_0003);
        check("R7", "global ctrl unchanged", 32'(glob_ctrl_o), 32'h5);
    endtask

    task automatic t_hw();
        logic [31:0] d;
        wr(ch_addr(0, 2), 32'h0777);
        @(negedge clk);
        hw_ch_upd = 3'b010;
        hw_ch_mem[32 +: 32] = 32'hFFFF_FFFF;
        hw_ch_cnt[16 +: 16] = 16'h1234;
        hw_ch_tag[32 +: 32] = 32'h8000_0015;
        @(negedge clk);
        hw_ch_upd = '0;
        rd(ch_addr(1, 1), d); check("R9", "ch1 mem from hw", d, 32'h7FFF_FFF0);
        rd(ch_addr(1, 2), d); check("R9", "ch1 count from hw", d, 32'h1234);
        rd(ch_addr(1, 3), d); check("R9", "ch1 tag from hw", d, 32'h0000_0010);
        check("R9", "ch1 cnt port", 32'(ch_cnt_o[31:16]), 32'h1234);
        rd(ch_addr(0, 2), d); check("R9", "ch0 count untouched", d, 32'h0777);
        // bus count write and hw update of channel 2 in one cycle
        @(negedge clk);
        hw_ch_upd = 3'b100;
        hw_ch_mem[64 +: 32] = 32'h0000_1234;
        hw_ch_cnt[32 +: 16] = 16'h1111;
        hw_ch_tag[64 +: 32] = 32'h0000_0550;
        bus_addr = ch_addr(2, 2); bus_wdata = 32'h2222; bus_we = 1'b1;
        @(negedge clk);
        hw_ch_upd = '0; bus_we = 1'b0;
        rd(ch_addr(2, 2), d); check("R10", "bus count wins", d, 32'h2222);
        rd(ch_addr(2, 1), d); check("R10", "hw mem still applied", d, 32'h0000_1230);
        rd(ch_addr(2, 3), d); check("R10", "hw tag still applied", d, 32'h0000_0550);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_status();
        t_unmapped();
        t_hw();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule